// File: doc/BRIEF.md
# SPI Serial Clock Prescaler

This block derives the serial bit clock of an SPI master from its parent clock. Software loads a 16-bit scale code, and the block decodes it into a division ratio. One code passes the parent clock straight through. The others give a power-of-two ratio from 2 to 1024, built from a 3-bit exponent field and an optional fixed divide-by-32 prestage. Transmit and receive paths share the same code format, so one instance can serve either path.

The block drives a serial clock with a selectable idle level. It also drives two single-cycle strobes in the parent clock domain, one for each rising and one for each falling serial clock edge, so the shift register can act on them without sampling the serial clock itself. An enable input gates the block. While the enable is low, the clock rests at its idle level and the internal counter is cleared. Each new enable therefore starts a fresh, full-length first half period. A code that is not in the supported set selects the slowest ratio, so an illegal setting can never run the link too fast.

Top module: `spi_sck_prescaler`

## Requirements
- R1: During and right after reset, `sck_o` equals `idle_hi_i`, and both `rise_stb_o` and `fall_stb_o` are low.
- R2: Code 0x0007 selects divide-by-1. While enabled, both strobes are high on every parent cycle from the cycle after the enable is sampled. `sck_o` equals the parent clock, inverted when `idle_hi_i` is 1.
- R3: With bits 12:8 and all other upper bits zero, a value L of 0 to 4 in bits 2:0 selects a ratio of 2^(L+1), which covers 2, 4, 8, 16 and 32.
- R4: With bits 12:8 equal to 0x1F and a value L of 0 to 4 in bits 2:0, the ratio is 2^(L+6), which covers 64 up to 1024.
- R5: Every other code selects a ratio of 1024. This includes any nonzero bit in 15:13 or 7:3, other upper-field values, and low values 5 to 7 outside the bypass code.
- R6: A divided clock has a 50% duty cycle, with half period H = ratio/2. Counting parent cycles from the first edge that samples the enable high as cycle 0, the first transition is visible after cycle H-1, and further transitions follow every H cycles.
- R7: In divided mode, `rise_stb_o` is high for exactly the one parent cycle in which `sck_o` has just gone from 0 to 1, and `fall_stb_o` likewise for 1 to 0.
- R8: One parent cycle after `en_i` is sampled low, `sck_o` is back at its idle level and both strobes are low. A later enable restarts the half-period count from zero.
- R9: `idle_hi_i` sets the idle level. With `idle_hi_i` at 1, the clock idles high, so the first edge after enabling is falling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Parent clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable; low holds the clock idle and clears the counter |
| idle_hi_i | input | 1 | Idle level of the serial clock |
| scale_code_i | input | 16 | Scale code: bits 2:0 exponent, bits 12:8 prestage select |
| sck_o | output | 1 | Serial bit clock |
| rise_stb_o | output | 1 | One-cycle strobe for each rising serial clock edge |
| fall_stb_o | output | 1 | One-cycle strobe for each falling serial clock edge |

## Verification
A table walks every legal exponent, both with and without the prestage, plus several malformed codes. The malformed codes set stray upper bits, use a wrong prestage value, or carry an out-of-range exponent. For each code the bench measures the first-edge delay, the high time and the strobe counts over two periods. The delay and high time tell each ratio apart from its neighbours, and the malformed codes prove they land on 1024 rather than on a faster ratio. Directed runs then cover the high idle level, a disable in the middle of a period followed by a re-enable, and the bypass code. Together these separate the idle-polarity, restart and pass-through paths from the divided path.

// File: rtl/spi_sck_pkg.sv
package spi_sck_pkg;
  parameter int CODE_W    = 16;
  parameter int LOW_W     = 3;
  parameter int HI_LSB    = 8;
  parameter int HI_W      = 5;
  parameter int PRE_EXP   = 5;
  parameter logic [HI_W-1:0]   PRE_FIELD   = 5'h1F;
  parameter logic [CODE_W-1:0] BYPASS_CODE = 16'h0007;

  localparam int MAX_EXP = 2 * PRE_EXP;
  localparam int LOW_MAX = PRE_EXP - 1;
  localparam int EXP_W   = $clog2(MAX_EXP + 1);
  localparam int CNT_W   = MAX_EXP - 1;
  localparam logic [CODE_W-1:0] FIELD_MASK =
    CODE_W'((((1 << HI_W) - 1) << HI_LSB) | ((1 << LOW_W) - 1));

  typedef struct packed {
    logic             bypass;
    logic [EXP_W-1:0] expo;
  } ratio_sel_t;
endpackage

// File: rtl/sck_code_decode.sv
module sck_code_decode
  import spi_sck_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output ratio_sel_t        sel_o,
  output logic [CNT_W-1:0]  half_m1_o
);
  logic [LOW_W-1:0]   low_f;
  logic [HI_W-1:0]    hi_f;
  logic               clean;
  logic               low_ok;
  logic [MAX_EXP-1:0] half_full;

  assign low_f  = code_i[LOW_W-1:0];
  assign hi_f   = code_i[HI_LSB+HI_W-1:HI_LSB];
  assign clean  = (code_i & ~FIELD_MASK) == '0;
  assign low_ok = int'(low_f) <= LOW_MAX;

  always_comb begin
    sel_o.bypass = 1'b0;
    sel_o.expo   = EXP_W'(MAX_EXP);
    if (code_i == BYPASS_CODE) begin
      sel_o.bypass = 1'b1;
    end else if (clean && low_ok && hi_f == '0) begin
      sel_o.expo = EXP_W'(low_f) + EXP_W'(1);
    end else if (clean && low_ok && hi_f == PRE_FIELD) begin
      sel_o.expo = EXP_W'(low_f) + EXP_W'(1 + PRE_EXP);
    end
  end

  assign half_full = MAX_EXP'(1) << (sel_o.expo - EXP_W'(1));
  assign half_m1_o = CNT_W'(half_full - MAX_EXP'(1));
endmodule

// File: rtl/sck_half_counter.sv
module sck_half_counter
  import spi_sck_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] half_m1_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q >= half_m1_i);

  always_ff @(posedge clk_i) begin
    if (rst_i || !run_i) begin
      cnt_q <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_i && $stable(half_m1_i)) |-> (cnt_q <= half_m1_i)); // R6
endmodule

// File: rtl/sck_edge_gen.sv
module sck_edge_gen (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  input  logic idle_hi_i,
  input  logic bypass_i,
  input  logic tick_i,
  output logic sck_q_o,
  output logic rise_q_o,
  output logic fall_q_o,
  output logic byp_q_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) begin
      sck_q_o  <= idle_hi_i;
      rise_q_o <= 1'b0;
      fall_q_o <= 1'b0;
      byp_q_o  <= 1'b0;
    end else if (bypass_i) begin
      sck_q_o  <= idle_hi_i;
      rise_q_o <= 1'b1;
      fall_q_o <= 1'b1;
      byp_q_o  <= 1'b1;
    end else begin
      byp_q_o  <= 1'b0;
      rise_q_o <= tick_i && !sck_q_o;
      fall_q_o <= tick_i && sck_q_o;
      if (tick_i) sck_q_o <= !sck_q_o;
    end
  end

  AST_RISE_MATCH: assert property (@(posedge clk_i) disable iff (rst_i)
    (rise_q_o && !byp_q_o) |-> (sck_q_o && !$past(sck_q_o))); // R7
  AST_FALL_MATCH: assert property (@(posedge clk_i) disable iff (rst_i)
    (fall_q_o && !byp_q_o) |-> (!sck_q_o && $past(sck_q_o))); // R7
endmodule

// File: rtl/spi_sck_prescaler.sv
module spi_sck_prescaler
  import spi_sck_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              en_i,
  input  logic              idle_hi_i,
  input  logic [CODE_W-1:0] scale_code_i,
  output logic              sck_o,
  output logic              rise_stb_o,
  output logic              fall_stb_o
);
  ratio_sel_t       sel;
  logic [CNT_W-1:0] half_m1;
  logic             tick;
  logic             sck_q;
  logic             byp_q;

  sck_code_decode u_dec (
    .code_i    (scale_code_i),
    .sel_o     (sel),
    .half_m1_o (half_m1)
  );

  sck_half_counter u_cnt (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .run_i     (en_i && !sel.bypass),
    .half_m1_i (half_m1),
    .tick_o    (tick)
  );

  sck_edge_gen u_edge (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .en_i      (en_i),
    .idle_hi_i (idle_hi_i),
    .bypass_i  (sel.bypass),
    .tick_i    (tick),
    .sck_q_o   (sck_q),
    .rise_q_o  (rise_stb_o),
    .fall_q_o  (fall_stb_o),
    .byp_q_o   (byp_q)
  );

  assign sck_o = byp_q ? (idle_hi_i ^ clk_i) : sck_q;

  AST_IDLE_ON_STOP: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> (sck_o == $past(idle_hi_i) && !rise_stb_o && !fall_stb_o)); // R8
  AST_BYPASS_STB: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && scale_code_i == BYPASS_CODE) |=> (rise_stb_o && fall_stb_o)); // R2
endmodule

// File: tb/spi_sck_prescaler_tb_top.sv
module spi_sck_prescaler_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        idle_hi = 1'b1;
  logic [15:0] code = 16'h0000;
  logic        sck, rise, fall;
  int          checks = 0;
  int          errors = 0;

  always #4 clk = ~clk;

  spi_sck_prescaler dut_i (
    .clk_i(clk), .rst_i(rst), .en_i(en), .idle_hi_i(idle_hi),
    .scale_code_i(code), .sck_o(sck), .rise_stb_o(rise), .fall_stb_o(fall)
  );

  // {code, expected ratio}: R3 legal low field, R4 prestage, R5 malformed
  localparam logic [31:0] VEC [0:13] = '{
    {16'h0000, 16'd2},    {16'h0001, 16'd4},    {16'h0002, 16'd8},
    {16'h0003, 16'd16},   {16'h0004, 16'd32},   {16'h1F00, 16'd64},
    {16'h1F01, 16'd128},  {16'h1F02, 16'd256},  {16'h1F03, 16'd512},
    {16'h1F04, 16'd1024}, {16'h0005, 16'd1024}, {16'h1F07, 16'd1024},
    {16'h0100, 16'd1024}, {16'h8002, 16'd1024}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Enable with a code and measure two periods (R6, R7, R9 and the ratio tag).
  task automatic run_ratio(input logic [15:0] c, input int ratio, input logic ih,
                           input string req);
    int h, first, highs, rises, falls, bad;
    logic prev;
    h = ratio / 2; first = -1; highs = 0; rises = 0; falls = 0; bad = 0;
    @(negedge clk); en = 1'b0; code = c; idle_hi = ih;
    @(negedge clk); en = 1'b1; prev = ih;
    for (int j = 0; j < 2 * ratio; j++) begin
      @(negedge clk);
      if (sck != ih) highs++;
      if (first < 0 && sck != ih) first = j;
      if (rise) begin rises++; if (!(sck && !prev)) bad++; end
      if (fall) begin falls++; if (!(!sck && prev)) bad++; end
      prev = sck;
    end
    en = 1'b0;
    chk(first == h - 1, {req, " R6 first edge"}, first, h - 1);
    chk(highs == ratio, {req, " R6 duty"}, highs, ratio);
    chk(rises == 2 && falls == 2, {req, " R7 strobe count"}, rises * 10 + falls, 22);
    chk(bad == 0, {req, " R7 strobe alignment"}, bad, 0);
  endtask

  initial begin
    int wd = 0;
    while (wd < 200000) begin @(posedge clk); wd++; end
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", wd);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int first;
    repeat (3) @(negedge clk);
    chk(sck == 1'b1, "R1 reset sck", sck, 1);
    chk(!rise && !fall, "R1 reset strobes", rise + fall, 0);
    rst = 1'b0;

    for (int i = 0; i < 14; i++) begin
      string tag;
      if (i < 5) tag = "R3"; else if (i < 10) tag = "R4"; else tag = "R5";
      run_ratio(VEC[i][31:16], int'(VEC[i][15:0]), 1'b0, tag);
    end

    // R9 idle high: first edge falls
    run_ratio(16'h0001, 4, 1'b1, "R9");

    // R8 disable mid-high, then clean restart
    @(negedge clk); en = 1'b0; code = 16'h0002; idle_hi = 1'b0;
    @(negedge clk); en = 1'b1;
    repeat (5) @(negedge clk);
    chk(sck == 1'b1, "R8 pre-stop high", sck, 1);
    en = 1'b0;
    @(negedge clk);
    chk(sck == 1'b0, "R8 idle after stop", sck, 0);
    chk(!rise && !fall, "R8 strobes after stop", rise + fall, 0);
    en = 1'b1; first = -1;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      if (first < 0 && sck) first = j;
    end
    chk(first == 3, "R8 restart first edge", first, 3);
    en = 1'b0;

    // R2 bypass
    @(negedge clk); code = 16'h0007; idle_hi = 1'b0;
    @(negedge clk); en = 1'b1;
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      chk(rise && fall, "R2 bypass strobes", rise + fall, 2);
      chk(sck == 1'b0, "R2 bypass sck low phase", sck, 0);
      @(posedge clk); #1;
      chk(sck == 1'b1, "R2 bypass sck high phase", sck, 1);
    end
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    chk(!rise && !fall && sck == 1'b0, "R2 bypass stop", rise + fall + sck, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule